// File: doc/BRIEF.md
# Periodic Update Strobe Generator

This block produces a recurring internal update event at a programmable rate, together with an external active-high strobe that announces each event. A 2-bit rate code picks a power-of-two slow-down (1, 2, 4 or 8) of the system clock. The slowed tick advances an interval counter whose span is a 32-bit interval value. One update period therefore lasts 2^code × interval system clocks. Each period ends with a single-cycle update pulse. At the same moment the strobe rises, and it stays high for a width that scales with the rate code.

The rate code and interval are sampled continuously at the inputs, but the generator only adopts them at the end of a period. A new setting therefore never truncates or stretches a period already in progress. Very small intervals switch the strobe from pulsing to a steady high level. When the enable input is low, the generator is idle, its outputs are quiet, and its counters are held at zero, so a new enable always starts a full period.

The asynchronous active-low reset is released through a two-flop synchronizer. The core therefore starts counting on the third rising edge after the reset input goes high.

Top module: `upd_strobe_gen`

## Requirements
- R1: With active rate code A and active interval B, update pulses recur every 2^A × B system clocks; an interval of 0 behaves as 1.
- R2: `upd_pulse` is high for exactly one clock per period. After enable is first sampled high on a rising edge (edge 1), the first pulse is visible after edge 2^A × B, and later pulses follow one period apart.
- R3: In pulsing mode, `strobe_out` rises in the same cycle as `upd_pulse` and stays high for 12 × 2^A clocks, where A is the code adopted at that pulse.
- R4: If that width is greater than or equal to the new period, it is cut to the period minus one, so the strobe is low for at least one clock before the next pulse.
- R5: While enabled with an active interval of 3 or less, `strobe_out` is a steady logic 1 instead of a pulse train.
- R6: The `rate_code` and `interval` inputs become active only on the edge that raises `upd_pulse`. Changes between pulses do not alter the period being counted.
- R7: After reset, all outputs are low and the active setting is code 0 with interval 0x0000FFFF, so the first period lasts 65535 clocks whatever the inputs show.
- R8: One edge after `enable` is sampled low, `upd_pulse` and `strobe_out` are low and stay low. The counters clear, so the next enable restarts the period from zero with the active setting kept.
- R9: `strobe_oe` equals `enable` delayed by one clock; it is low during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Runs the generator when high |
| rate_code | input | 2 | Prescale code: divide by 2^code; also selects strobe width |
| interval | input | 32 | Number of prescaled ticks per period |
| upd_pulse | output | 1 | One-clock internal update event |
| strobe_out | output | 1 | Active-high external strobe |
| strobe_oe | output | 1 | Output-enable flag for the strobe pin |

## Verification
After a reset release, the core responds from the third edge, so the first update arrives 2^A × B edges later. Each later pulse is due exactly one period after the previous one. The strobe rises on the same edge as the pulse. `strobe_oe` and the idle state follow `enable` by a single edge. The bench steps a behavioural model on each rising edge and compares all three outputs at the next falling edge, so every expected value is taken in the cycle in which the registered outputs have settled. Window counts of pulses and strobe-high cycles are taken over whole multiples of the period, so they do not depend on phase.

// File: rtl/upd_pkg.sv
package upd_pkg;

  // Default widths and constants of the update generator.
  localparam int unsigned UPD_CODE_W     = 2;
  localparam int unsigned UPD_CNT_W      = 32;
  localparam int unsigned UPD_BASE_WIDTH = 12;
  localparam int unsigned UPD_STATIC_MAX = 3;

  // Largest shift a rate code of the given width can request.
  function automatic int unsigned max_div_log(input int unsigned code_w);
    return (1 << code_w) - 1;
  endfunction

  // Bits needed to count up to a value (inclusive).
  function automatic int unsigned bits_for(input int unsigned value);
    int unsigned n;
    n = 1;
    while ((1 << n) <= value) n++;
    return n;
  endfunction

endpackage

// File: rtl/upd_rst_sync.sv
module upd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/upd_prescaler.sv
module upd_prescaler #(
  parameter int unsigned CODE_W = upd_pkg::UPD_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] shift,
  output logic              tick
);

  localparam int unsigned MAX_LOG = upd_pkg::max_div_log(CODE_W);

  generate
    if (MAX_LOG == 0) begin : g_bypass
      assign tick = run;
    end else begin : g_div
      localparam int unsigned PS_W = MAX_LOG;

      logic [PS_W-1:0] ps_q;
      logic [PS_W-1:0] ps_d;
      logic [PS_W-1:0] mask;
      logic            hit;

      always_comb begin
        mask = ~({PS_W{1'b1}} << shift);
        hit  = (ps_q == mask);
        tick = run & hit;
        if (!run) begin
          ps_d = '0;
        end else if (hit) begin
          ps_d = '0;
        end else begin
          ps_d = ps_q + PS_W'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ps_q <= '0;
        end else begin
          ps_q <= ps_d;
        end
      end

      // R1: the divider phase never passes the terminal value of the selected ratio
      p_presc_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ps_q <= mask));
    end
  endgenerate

endmodule

// File: rtl/upd_interval_cnt.sv
module upd_interval_cnt #(
  parameter int unsigned CNT_W = upd_pkg::UPD_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             term
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last;

  always_comb begin
    last = (limit == '0) ? '0 : (limit - CNT_W'(1));
    term = tick && (cnt_q == last);
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = term ? '0 : (cnt_q + CNT_W'(1));
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R1: the tick count stays inside the programmed span
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last));

  // R8: a stopped counter sits at zero
  p_cnt_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/upd_strobe_shaper.sv
module upd_strobe_shaper #(
  parameter int unsigned CODE_W     = upd_pkg::UPD_CODE_W,
  parameter int unsigned CNT_W      = upd_pkg::UPD_CNT_W,
  parameter int unsigned BASE_WIDTH = upd_pkg::UPD_BASE_WIDTH,
  parameter int unsigned STATIC_MAX = upd_pkg::UPD_STATIC_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              term,
  input  logic [CODE_W-1:0] nxt_code,
  input  logic [CNT_W-1:0]  nxt_limit,
  input  logic [CNT_W-1:0]  sel_limit,
  output logic              strobe,
  output logic              oe
);

  localparam int unsigned MAX_LOG = upd_pkg::max_div_log(CODE_W);
  localparam int unsigned WMAX    = BASE_WIDTH << MAX_LOG;
  localparam int unsigned WC_W    = upd_pkg::bits_for(WMAX);
  localparam int unsigned LEN_W   = CNT_W + MAX_LOG + 1;

  logic [CNT_W-1:0] lim_eff;
  logic [LEN_W-1:0] per_len;
  logic [LEN_W-1:0] raw_w;
  logic [LEN_W-1:0] cut_w;
  logic [WC_W-1:0]  load_w;
  logic             static_nxt;

  logic [WC_W-1:0]  wcnt_q, wcnt_d;
  logic             strb_q, strb_d;
  logic             stat_q, stat_d;
  logic             oe_q,   oe_d;

  // Width for the period that starts at this pulse, cut below the period.
  always_comb begin
    lim_eff    = (nxt_limit == '0) ? CNT_W'(1) : nxt_limit;
    per_len    = LEN_W'(lim_eff) << nxt_code;
    raw_w      = LEN_W'(BASE_WIDTH) << nxt_code;
    cut_w      = (raw_w >= per_len) ? (per_len - LEN_W'(1)) : raw_w;
    load_w     = WC_W'(cut_w);
    static_nxt = (sel_limit <= CNT_W'(STATIC_MAX));
  end

  always_comb begin
    wcnt_d = wcnt_q;
    strb_d = strb_q;
    stat_d = stat_q;
    oe_d   = oe_q;
    if (!run) begin
      wcnt_d = '0;
      strb_d = 1'b0;
      stat_d = 1'b0;
      oe_d   = 1'b0;
    end else begin
      oe_d   = 1'b1;
      stat_d = static_nxt;
      if (term) begin
        strb_d = 1'b1;
        wcnt_d = static_nxt ? '0 : (load_w - WC_W'(1));
      end else begin
        strb_d = (wcnt_q != '0);
        wcnt_d = (wcnt_q != '0) ? (wcnt_q - WC_W'(1)) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      strb_q <= 1'b0;
      stat_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      strb_q <= strb_d;
      stat_q <= stat_d;
      oe_q   <= oe_d;
    end
  end

  assign strobe = strb_q | stat_q;
  assign oe     = oe_q;

  // R4: the width countdown has run out before the next period ends
  p_gap_before_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    term |-> (wcnt_q == '0));

  // R3: the countdown never exceeds the widest strobe
  p_width_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q < WC_W'(WMAX));

  // R5: a small active interval gives a steady high strobe
  p_static_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (sel_limit <= CNT_W'(STATIC_MAX))) |=> strobe);

  // R8, R9: disabling silences the strobe and drops the output enable
  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!strobe && !oe));

endmodule

// File: rtl/upd_strobe_gen.sv
module upd_strobe_gen #(
  parameter int unsigned    CODE_W     = upd_pkg::UPD_CODE_W,
  parameter int unsigned    CNT_W      = upd_pkg::UPD_CNT_W,
  parameter int unsigned    BASE_WIDTH = upd_pkg::UPD_BASE_WIDTH,
  parameter int unsigned    STATIC_MAX = upd_pkg::UPD_STATIC_MAX,
  parameter logic [CNT_W-1:0] RST_LIMIT = CNT_W'(32'h0000_FFFF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CODE_W-1:0] rate_code,
  input  logic [CNT_W-1:0]  interval,
  output logic              upd_pulse,
  output logic              strobe_out,
  output logic              strobe_oe
);

  logic              srst_n;
  logic              tick;
  logic              term;
  logic [CODE_W-1:0] act_code_q, act_code_d;
  logic [CNT_W-1:0]  act_lim_q,  act_lim_d;
  logic [CNT_W-1:0]  sel_limit;
  logic              upd_q, upd_d;

  upd_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  upd_prescaler #(.CODE_W(CODE_W)) u_prescaler (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (enable),
    .shift (act_code_q),
    .tick  (tick)
  );

  upd_interval_cnt #(.CNT_W(CNT_W)) u_interval (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (enable),
    .tick  (tick),
    .limit (act_lim_q),
    .term  (term)
  );

  // Active setting is adopted only at the end of a period.
  always_comb begin
    act_code_d = term ? rate_code : act_code_q;
    act_lim_d  = term ? interval  : act_lim_q;
    sel_limit  = act_lim_d;
    upd_d      = term;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      act_code_q <= '0;
      act_lim_q  <= RST_LIMIT;
      upd_q      <= 1'b0;
    end else begin
      act_code_q <= act_code_d;
      act_lim_q  <= act_lim_d;
      upd_q      <= upd_d;
    end
  end

  upd_strobe_shaper #(
    .CODE_W     (CODE_W),
    .CNT_W      (CNT_W),
    .BASE_WIDTH (BASE_WIDTH),
    .STATIC_MAX (STATIC_MAX)
  ) u_shaper (
    .clk       (clk),
    .rst_n     (srst_n),
    .run       (enable),
    .term      (term),
    .nxt_code  (rate_code),
    .nxt_limit (interval),
    .sel_limit (sel_limit),
    .strobe    (strobe_out),
    .oe        (strobe_oe)
  );

  assign upd_pulse = upd_q;

  // R6: the active interval only moves on an update event
  p_cfg_on_update_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (act_lim_q != $past(act_lim_q)) |-> upd_pulse);

  // R6: the active code only moves on an update event
  p_code_on_update_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (act_code_q != $past(act_code_q)) |-> upd_pulse);

  // R8: no update event while disabled
  p_no_update_idle_r8: assert property (@(posedge clk) disable iff (!srst_n)
    !enable |=> !upd_pulse);

  // R3: every pulse comes with the strobe high
  p_strobe_with_pulse_r3: assert property (@(posedge clk) disable iff (!srst_n)
    upd_pulse |-> strobe_out);

endmodule

// File: tb/upd_strobe_gen_tb.sv
module upd_strobe_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [1:0]  rate_code;
  logic [31:0] interval;
  logic        upd_pulse;
  logic        strobe_out;
  logic        strobe_oe;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;
  string cur_tag = "R7";

  // Behavioural reference state
  longint ph = 0;
  longint ma = 0;
  longint mb = 32'h0000FFFF;
  longint rem = 0;
  bit m_upd = 0, m_strb = 0, m_stat = 0, m_oe = 0;
  bit r1 = 0, r2 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  upd_strobe_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .rate_code  (rate_code),
    .interval   (interval),
    .upd_pulse  (upd_pulse),
    .strobe_out (strobe_out),
    .strobe_oe  (strobe_oe)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: one step per rising edge
  always @(posedge clk) begin
    longint n_per, w;
    bit term;
    if (!rst_n) begin
      r1 = 0; r2 = 0; ph = 0; ma = 0; mb = 32'h0000FFFF; rem = 0;
      m_upd = 0; m_strb = 0; m_stat = 0; m_oe = 0;
    end else begin
      if (r2) begin
        if (!enable) begin
          ph = 0; rem = 0; m_upd = 0; m_strb = 0; m_stat = 0; m_oe = 0;
        end else begin
          n_per = ((mb == 0) ? 1 : mb) << ma;
          term  = (ph == n_per - 1);
          m_upd = term;
          m_oe  = 1;
          if (term) begin
            ma = rate_code; mb = interval; ph = 0;
            n_per = ((mb == 0) ? 1 : mb) << ma;
            w = 12 << ma;
            if (w >= n_per) w = n_per - 1;
            m_strb = 1;
            rem = (mb <= 3) ? 0 : w - 1;
          end else begin
            ph++;
            m_strb = (rem != 0);
            if (rem != 0) rem--;
          end
          m_stat = (mb <= 3);
        end
      end
      r2 = r1;
      r1 = 1;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R2 R8 upd_pulse", upd_pulse, m_upd);
      chk({cur_tag, " strobe_out"}, strobe_out, m_strb | m_stat);
      chk("R9 strobe_oe", strobe_oe, m_oe);
    end
  end

  task automatic window(input int n, output int p, output int s);
    p = 0; s = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      p += upd_pulse;
      s += strobe_out;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int p, s;
    rst_n = 1'b0; enable = 1'b0; rate_code = 2'd0; interval = 32'd0;
    idle(3);
    // R7: outputs low in reset
    chk("R7 reset upd", upd_pulse, 0);
    chk("R7 reset strobe", strobe_out, 0);
    chk("R7 reset oe", strobe_oe, 0);
    rst_n = 1'b1; enable = 1'b1; rate_code = 2'd0; interval = 32'd5;
    cur_tag = "R7";
    // R7: default period 65535 clocks; first pulse after edge 65537
    window(65539, p, s);
    chk("R7 default period pulses", p, 1);
    idle(1);
    cur_tag = "R4";
    // R1, R4: A=0 B=5, N=5, width 12 cut to 4
    window(50, p, s);
    chk("R1 pulses A0 B5", p, 10);
    chk("R4 strobe highs cut", s, 40);
    // R3, R6: A=1 B=100, N=200, width 24; adopted at next pulse
    rate_code = 2'd1; interval = 32'd100; cur_tag = "R3 R6";
    idle(10);
    window(400, p, s);
    chk("R6 pulses new period", p, 2);
    chk("R3 strobe width 24", s, 48);
    // R5: A=3 B=2, N=16, static high
    rate_code = 2'd3; interval = 32'd2; cur_tag = "R5";
    idle(250);
    window(96, p, s);
    chk("R1 pulses A3 B2", p, 6);
    chk("R5 static strobe", s, 96);
    // R8, R9: disable
    enable = 1'b0; cur_tag = "R8";
    idle(2);
    chk("R8 upd off", upd_pulse, 0);
    chk("R8 strobe off", strobe_out, 0);
    chk("R9 oe off", strobe_oe, 0);
    window(50, p, s);
    chk("R8 no pulses idle", p, 0);
    chk("R8 no strobe idle", s, 0);
    // R4, R8: re-enable with held setting, then A=2 B=6 (N=24, width 48 cut to 23)
    rate_code = 2'd2; interval = 32'd6; enable = 1'b1; cur_tag = "R4 R8";
    idle(20);
    chk("R9 oe on", strobe_oe, 1);
    window(48, p, s);
    chk("R1 pulses A2 B6", p, 2);
    chk("R4 strobe cut 23", s, 46);
    // R3: A=0 B=30, width 12
    rate_code = 2'd0; interval = 32'd30; cur_tag = "R3";
    idle(30);
    window(60, p, s);
    chk("R1 pulses A0 B30", p, 2);
    chk("R3 strobe width 12", s, 24);
    // R1, R5: interval 0 acts as 1, pulse every clock, steady strobe
    interval = 32'd0; cur_tag = "R5";
    idle(40);
    window(20, p, s);
    chk("R1 pulses B0", p, 20);
    chk("R5 static B0", s, 20);
    finish_run();
  end

endmodule